// File: doc/BRIEF.md
# Load-Store Instruction Decoder

This block is a purely combinational decoder for a small subset of a 32-bit, three-operand, load-store instruction set. It takes one instruction word and produces everything the rest of a simple core needs to execute it. That covers the raw register index fields, the extended immediate, an ALU operation code, the memory read and write strobes with a byte-width hint, and the register write enable with the chosen destination index. It also raises flags for conditional branches, direct jumps, linking jumps and register-indirect jumps, and it flags words it does not recognise.

Three layouts are recognised. The register layout is opcode 0 with a function code in the low six bits. The immediate layout carries a 16-bit constant in the low half. The jump layout carries a 26-bit target below the opcode. The destination is taken from the rd field, the rt field or a fixed link register, depending on the instruction. The immediate is sign-extended, zero-extended or placed in the upper half, depending on the opcode. Register 0 is hard-wired to zero, so a write aimed at it is dropped.

Top module: `isa_decoder`

## Requirements
- R1: rs_o, rt_o and rd_o always equal instruction bits [25:21], [20:16] and [15:11], whatever the opcode.
- R2: With opcode 0, function 32 (add), 34 (sub) and 42 (slt) give alu_op_o 0, 1 and 2 respectively and select rd as destination with a register write.
- R3: Opcodes 8 (addi), 10 (slti), 13 (ori) and 15 (lui) give alu_op_o 0, 2, 3 and 4 respectively and select rt as destination with a register write.
- R4: imm_o is the low 16 bits zero-extended for opcode 13, the low 16 bits shifted into the upper half with the low half zero for opcode 15, and sign-extended for every other word.
- R5: Opcodes 35 (word load) and 32 (byte load) assert mem_rd_o, select rt as destination with a register write, and use alu_op_o 0; mem_byte_o is 1 only for the byte form.
- R6: Opcodes 43 (word store) and 40 (byte store) assert mem_wr_o with alu_op_o 0 and no register write; mem_byte_o is 1 only for the byte form.
- R7: Opcodes 4 and 5 assert branch_o with alu_op_o 1 and no write; branch_ne_o is 1 only for opcode 5.
- R8: Opcode 2 asserts jump_o alone; opcode 3 asserts jump_o and link_o and writes register 31.
- R9: Opcode 0 with function 8 asserts jump_reg_o and performs no register write.
- R10: When the selected destination index is 0, reg_we_o is 0 while reg_dst_o still shows 0; for instructions that write nothing, reg_dst_o is 0.
- R11: Any opcode outside the subset, or opcode 0 with a function outside {8, 32, 34, 42}, raises illegal_o and clears every enable and flag, with reg_dst_o 0 and alu_op_o 0.
- R12: At most one of mem_rd_o, mem_wr_o, branch_o, jump_o and jump_reg_o is ever 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second source / immediate-form destination field |
| rd_o | output | 5 | Register-form destination field |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 3 | ALU operation: 0 add, 1 subtract, 2 set-less-than, 3 or, 4 pass second operand |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_byte_o | output | 1 | Memory access is one byte wide |
| reg_we_o | output | 1 | Register file write enable |
| reg_dst_o | output | 5 | Register file write index |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch condition is inequality |
| jump_o | output | 1 | Direct jump to the 26-bit target |
| link_o | output | 1 | Jump also saves the return address |
| jump_reg_o | output | 1 | Jump to the address in rs |
| illegal_o | output | 1 | Word is outside the decoded subset |

## Verification
Two functions meet in the same decode in two places. A linking jump raises the jump flag and also writes the link register. A legal write whose destination field is 0 decodes correctly but must have its write enable removed. The bench provokes the first with a linking jump and the second with an immediate add and a register-form add that both target register 0. For each word, the bench judges the control flags and the write enable together against a model built from the requirements. It checks that the jump and the write both appear in the first case, and that in the second case only the write disappears, with the destination index still shown.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

   localparam int OP_W    = 6;
   localparam int FUNCT_W = 6;

   localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
   localparam logic [OP_W-1:0] OPC_J     = 6'd2;
   localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
   localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
   localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
   localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
   localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
   localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
   localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
   localparam logic [OP_W-1:0] OPC_LB    = 6'd32;
   localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
   localparam logic [OP_W-1:0] OPC_SB    = 6'd40;
   localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

   localparam logic [FUNCT_W-1:0] FN_JR  = 6'd8;
   localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
   localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
   localparam logic [FUNCT_W-1:0] FN_SLT = 6'd42;

   typedef enum logic [2:0] {
      ALU_ADD   = 3'd0,
      ALU_SUB   = 3'd1,
      ALU_SLT   = 3'd2,
      ALU_OR    = 3'd3,
      ALU_PASSB = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      EXT_SIGN  = 2'd0,
      EXT_ZERO  = 2'd1,
      EXT_UPPER = 2'd2
   } ext_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RD   = 2'd1,
      DST_RT   = 2'd2,
      DST_LINK = 2'd3
   } dst_e;

   typedef struct packed {
      alu_op_e alu;
      ext_e    ext;
      dst_e    dst;
      logic    mem_rd;
      logic    mem_wr;
      logic    mem_byte;
      logic    branch;
      logic    br_ne;
      logic    jump;
      logic    link;
      logic    jreg;
      logic    illegal;
   } ctrl_t;

endpackage

// File: rtl/isa_dec_fields.sv
module isa_dec_fields
   import isa_dec_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int RADDR_W = 5,
   parameter int IMM_W   = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [OP_W-1:0]    op,
   output logic [FUNCT_W-1:0] funct,
   output logic [RADDR_W-1:0] rs,
   output logic [RADDR_W-1:0] rt,
   output logic [RADDR_W-1:0] rd,
   output logic [IMM_W-1:0]   imm
);
   localparam int RS_LSB = INSTR_W - OP_W - RADDR_W;
   localparam int RT_LSB = RS_LSB - RADDR_W;
   localparam int RD_LSB = RT_LSB - RADDR_W;

   if (RD_LSB < FUNCT_W) begin : g_bad_rd
      $error("register fields overlap the function code");
   end
   if (IMM_W > RT_LSB) begin : g_bad_imm
      $error("immediate overlaps the rt field");
   end

   assign op    = instr[INSTR_W-1 -: OP_W];
   assign rs    = instr[RS_LSB +: RADDR_W];
   assign rt    = instr[RT_LSB +: RADDR_W];
   assign rd    = instr[RD_LSB +: RADDR_W];
   assign funct = instr[FUNCT_W-1:0];
   assign imm   = instr[IMM_W-1:0];
endmodule

// File: rtl/isa_dec_ctrl.sv
module isa_dec_ctrl
   import isa_dec_pkg::*;
(
   input  logic [OP_W-1:0]    op,
   input  logic [FUNCT_W-1:0] funct,
   output ctrl_t              ctrl
);
   always_comb begin
      ctrl = '0;
      unique case (op)
         OPC_RTYPE: begin
            unique case (funct)
               FN_ADD: begin ctrl.alu = ALU_ADD; ctrl.dst = DST_RD; end
               FN_SUB: begin ctrl.alu = ALU_SUB; ctrl.dst = DST_RD; end
               FN_SLT: begin ctrl.alu = ALU_SLT; ctrl.dst = DST_RD; end
               FN_JR:  ctrl.jreg = 1'b1;
               default: ctrl.illegal = 1'b1;
            endcase
         end
         OPC_J:    ctrl.jump = 1'b1;
         OPC_JAL: begin
            ctrl.jump = 1'b1;
            ctrl.link = 1'b1;
            ctrl.dst  = DST_LINK;
         end
         OPC_BEQ: begin ctrl.branch = 1'b1; ctrl.alu = ALU_SUB; end
         OPC_BNE: begin
            ctrl.branch = 1'b1;
            ctrl.br_ne  = 1'b1;
            ctrl.alu    = ALU_SUB;
         end
         OPC_ADDI: ctrl.dst = DST_RT;
         OPC_SLTI: begin ctrl.alu = ALU_SLT; ctrl.dst = DST_RT; end
         OPC_ORI: begin
            ctrl.alu = ALU_OR;
            ctrl.ext = EXT_ZERO;
            ctrl.dst = DST_RT;
         end
         OPC_LUI: begin
            ctrl.alu = ALU_PASSB;
            ctrl.ext = EXT_UPPER;
            ctrl.dst = DST_RT;
         end
         OPC_LW: begin ctrl.mem_rd = 1'b1; ctrl.dst = DST_RT; end
         OPC_LB: begin
            ctrl.mem_rd   = 1'b1;
            ctrl.mem_byte = 1'b1;
            ctrl.dst      = DST_RT;
         end
         OPC_SW: ctrl.mem_wr = 1'b1;
         OPC_SB: begin ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1; end
         default: ctrl.illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/isa_dec_imm.sv
module isa_dec_imm
   import isa_dec_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   input  ext_e             ext,
   output logic [XLEN-1:0]  value
);
   localparam int PAD_W = XLEN - IMM_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("data width must exceed the immediate width");
   end

   always_comb begin
      unique case (ext)
         EXT_ZERO:  value = {{PAD_W{1'b0}}, imm};
         EXT_UPPER: value = {imm, {PAD_W{1'b0}}};
         default:   value = {{PAD_W{imm[IMM_W-1]}}, imm};
      endcase
   end
endmodule

// File: rtl/isa_dec_dst.sv
module isa_dec_dst
   import isa_dec_pkg::*;
#(
   parameter int RADDR_W    = 5,
   parameter int LINK_IDX   = 31,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  dst_e               dst,
   input  logic [RADDR_W-1:0] rt,
   input  logic [RADDR_W-1:0] rd,
   output logic [RADDR_W-1:0] idx,
   output logic               we
);
   localparam logic [RADDR_W-1:0] LINK = RADDR_W'(LINK_IDX);

   if (LINK_IDX >= (1 << RADDR_W) || LINK_IDX < 1) begin : g_bad_link
      $error("link register index out of range");
   end

   logic want;

   always_comb begin
      unique case (dst)
         DST_RD:   idx = rd;
         DST_RT:   idx = rt;
         DST_LINK: idx = LINK;
         default:  idx = '0;
      endcase
   end

   assign want = (dst != DST_NONE);

   if (ZERO_GUARD) begin : g_guard
      assign we = want && (idx != '0);
   end else begin : g_plain
      assign we = want;
   end
endmodule

// File: rtl/isa_decoder.sv
module isa_decoder
   import isa_dec_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int RADDR_W    = 5,
   parameter int IMM_W      = 16,
   parameter int LINK_IDX   = 31,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [XLEN-1:0]    instr_i,
   output logic [RADDR_W-1:0] rs_o,
   output logic [RADDR_W-1:0] rt_o,
   output logic [RADDR_W-1:0] rd_o,
   output logic [XLEN-1:0]    imm_o,
   output logic [2:0]         alu_op_o,
   output logic               mem_rd_o,
   output logic               mem_wr_o,
   output logic               mem_byte_o,
   output logic               reg_we_o,
   output logic [RADDR_W-1:0] reg_dst_o,
   output logic               branch_o,
   output logic               branch_ne_o,
   output logic               jump_o,
   output logic               link_o,
   output logic               jump_reg_o,
   output logic               illegal_o
);
   logic [OP_W-1:0]    op;
   logic [FUNCT_W-1:0] funct;
   logic [IMM_W-1:0]   imm_raw;
   ctrl_t              ctrl;

   isa_dec_fields #(
      .INSTR_W(XLEN), .RADDR_W(RADDR_W), .IMM_W(IMM_W)
   ) u_fields (
      .instr(instr_i), .op(op), .funct(funct),
      .rs(rs_o), .rt(rt_o), .rd(rd_o), .imm(imm_raw)
   );

   isa_dec_ctrl u_ctrl (
      .op(op), .funct(funct), .ctrl(ctrl)
   );

   isa_dec_imm #(
      .XLEN(XLEN), .IMM_W(IMM_W)
   ) u_imm (
      .imm(imm_raw), .ext(ctrl.ext), .value(imm_o)
   );

   isa_dec_dst #(
      .RADDR_W(RADDR_W), .LINK_IDX(LINK_IDX), .ZERO_GUARD(ZERO_GUARD)
   ) u_dst (
      .dst(ctrl.dst), .rt(rt_o), .rd(rd_o), .idx(reg_dst_o), .we(reg_we_o)
   );

   assign alu_op_o    = ctrl.alu;
   assign mem_rd_o    = ctrl.mem_rd;
   assign mem_wr_o    = ctrl.mem_wr;
   assign mem_byte_o  = ctrl.mem_byte;
   assign branch_o    = ctrl.branch;
   assign branch_ne_o = ctrl.br_ne;
   assign jump_o      = ctrl.jump;
   assign link_o      = ctrl.link;
   assign jump_reg_o  = ctrl.jreg;
   assign illegal_o   = ctrl.illegal;
endmodule

// File: rtl/isa_decoder_chk.sv
module isa_decoder_chk #(
   parameter int XLEN     = 32,
   parameter int RADDR_W  = 5,
   parameter int LINK_IDX = 31
) (
   input logic [XLEN-1:0]    instr_i,
   input logic [XLEN-1:0]    imm_o,
   input logic               mem_rd_o,
   input logic               mem_wr_o,
   input logic               mem_byte_o,
   input logic               reg_we_o,
   input logic [RADDR_W-1:0] reg_dst_o,
   input logic               branch_o,
   input logic               jump_o,
   input logic               link_o,
   input logic               jump_reg_o,
   input logic               illegal_o
);
   always_comb begin
      assert_illegal_quiet_R11: assert (!illegal_o || !(reg_we_o || mem_rd_o
         || mem_wr_o || branch_o || jump_o || jump_reg_o || link_o));
      assert_zero_dst_R10: assert (!reg_we_o || reg_dst_o != '0);
      assert_exclusive_R12: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o,
         jump_o, jump_reg_o}));
      assert_store_nowrite_R6: assert (!mem_wr_o || !reg_we_o);
      assert_link_R8: assert (!link_o || (jump_o && reg_we_o
         && reg_dst_o == RADDR_W'(LINK_IDX)));
      assert_byte_mem_R5: assert (!mem_byte_o || mem_rd_o || mem_wr_o);
      assert_upper_low_zero_R4: assert (illegal_o
         || instr_i[XLEN-1 -: 6] != 6'd15 || imm_o[15:0] == 16'h0);
   end
endmodule

bind isa_decoder isa_decoder_chk #(
   .XLEN(XLEN), .RADDR_W(RADDR_W), .LINK_IDX(LINK_IDX)
) u_chk (
   .instr_i(instr_i), .imm_o(imm_o), .mem_rd_o(mem_rd_o),
   .mem_wr_o(mem_wr_o), .mem_byte_o(mem_byte_o), .reg_we_o(reg_we_o),
   .reg_dst_o(reg_dst_o), .branch_o(branch_o), .jump_o(jump_o),
   .link_o(link_o), .jump_reg_o(jump_reg_o), .illegal_o(illegal_o)
);

// File: tb/tb_isa_decoder.sv
module tb_isa_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;

   logic [4:0]  rs, rt, rd, dst;
   logic [31:0] imm;
   logic [2:0]  alu;
   logic        mrd, mwr, mbyte, we, br, brne, jmp, lnk, jr, ill;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   isa_decoder dut (
      .instr_i(instr), .rs_o(rs), .rt_o(rt), .rd_o(rd), .imm_o(imm),
      .alu_op_o(alu), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_byte_o(mbyte),
      .reg_we_o(we), .reg_dst_o(dst), .branch_o(br), .branch_ne_o(brne),
      .jump_o(jmp), .link_o(lnk), .jump_reg_o(jr), .illegal_o(ill)
   );

   typedef struct packed {
      logic [4:0]  rs, rt, rd;
      logic [31:0] imm;
      logic [2:0]  alu;
      logic        mrd, mwr, mbyte, we;
      logic [4:0]  dst;
      logic        br, brne, jmp, lnk, jr, ill;
   } exp_t;

   exp_t        q_exp[$];
   logic [31:0] q_word[$];
   string       q_tag[$];

   function automatic exp_t model(input logic [31:0] w);
      exp_t       e;
      logic [5:0] op;
      logic [5:0] fn;
      logic [4:0] d;
      logic       wr;
      op = w[31:26];
      fn = w[5:0];
      d  = 5'd0;
      wr = 1'b0;
      e  = '0;
      e.rs  = w[25:21];
      e.rt  = w[20:16];
      e.rd  = w[15:11];
      e.imm = {{16{w[15]}}, w[15:0]};
      case (op)
         6'd0: case (fn)
            6'd32: begin wr = 1; d = w[15:11]; end
            6'd34: begin wr = 1; d = w[15:11]; e.alu = 3'd1; end
            6'd42: begin wr = 1; d = w[15:11]; e.alu = 3'd2; end
            6'd8:  e.jr = 1;
            default: e.ill = 1;
         endcase
         6'd2:  e.jmp = 1;
         6'd3:  begin e.jmp = 1; e.lnk = 1; wr = 1; d = 5'd31; end
         6'd4:  begin e.br = 1; e.alu = 3'd1; end
         6'd5:  begin e.br = 1; e.brne = 1; e.alu = 3'd1; end
         6'd8:  begin wr = 1; d = w[20:16]; end
         6'd10: begin wr = 1; d = w[20:16]; e.alu = 3'd2; end
         6'd13: begin wr = 1; d = w[20:16]; e.alu = 3'd3;
                      e.imm = {16'h0, w[15:0]}; end
         6'd15: begin wr = 1; d = w[20:16]; e.alu = 3'd4;
                      e.imm = {w[15:0], 16'h0}; end
         6'd32: begin wr = 1; d = w[20:16]; e.mrd = 1; e.mbyte = 1; end
         6'd35: begin wr = 1; d = w[20:16]; e.mrd = 1; end
         6'd40: begin e.mwr = 1; e.mbyte = 1; end
         6'd43: e.mwr = 1;
         default: e.ill = 1;
      endcase
      e.dst = d;
      e.we  = wr && (d != 5'd0);
      return e;
   endfunction

   function automatic logic [31:0] rtype(input int s, input int t,
                                         input int d, input int f);
      return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
   endfunction

   function automatic logic [31:0] itype(input int o, input int s,
                                         input int t, input logic [15:0] k);
      return {6'(o), 5'(s), 5'(t), k};
   endfunction

   task automatic drive(input logic [31:0] w, input string tag);
      @(posedge clk);
      instr = w;
      q_exp.push_back(model(w));
      q_word.push_back(w);
      q_tag.push_back(tag);
   endtask

   // Monitor: compare at the falling edge, half a period after the drive.
   initial begin
      forever begin
         @(negedge clk);
         if (q_exp.size() > 0) begin
            exp_t        e;
            exp_t        a;
            logic [31:0] w;
            string       t;
            e = q_exp.pop_front();
            w = q_word.pop_front();
            t = q_tag.pop_front();
            a = '{rs, rt, rd, imm, alu, mrd, mwr, mbyte, we, dst,
                  br, brne, jmp, lnk, jr, ill};
            n_run++;
            if (a !== e) begin
               n_fail++;
               $display("FAIL %s instr=%h actual=%h expected=%h", t, w, a, e);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      drive(32'h0000_0000, "R11 reset word");
      drive(32'h0BAD_CAFE, "R1 fields");
      drive(rtype(17, 18, 8, 32), "R2 add");
      drive(rtype(9, 10, 11, 34), "R2 sub");
      drive(rtype(3, 4, 5, 42), "R2 slt");
      drive(itype(8, 29, 29, 16'hFFF0), "R3 R4 addi negative");
      drive(itype(10, 18, 8, 16'd10), "R3 slti");
      drive(itype(13, 8, 8, 16'h8001), "R3 R4 ori zero ext");
      drive(itype(15, 0, 8, 16'd255), "R3 R4 lui");
      drive(itype(35, 19, 8, 16'd32), "R5 lw");
      drive(itype(32, 9, 10, 16'h8000), "R5 lb");
      drive(itype(43, 9, 8, 16'd1200), "R6 sw");
      drive(itype(40, 3, 12, 16'hFFFF), "R6 sb");
      drive(itype(4, 19, 20, 16'd2), "R7 beq");
      drive(itype(5, 8, 21, 16'hFFFA), "R7 bne");
      drive({6'd2, 26'd20000}, "R8 j");
      drive({6'd3, 26'h3FF_FFFF}, "R8 jal link");
      drive(rtype(31, 0, 0, 8), "R9 jr");
      drive(itype(8, 5, 0, 16'd7), "R10 addi to zero");
      drive(rtype(1, 2, 0, 32), "R10 add to zero");
      drive(rtype(1, 2, 3, 63), "R11 bad funct");
      drive(itype(63, 1, 2, 16'h1234), "R11 bad opcode");
      drive(itype(1, 31, 31, 16'hFFFF), "R11 opcode 1");
      drive(itype(44, 7, 7, 16'h0), "R12 near store opcode");
      drive({6'd3, 26'd0}, "R12 jal zero target");
      repeat (3) @(posedge clk);
      if (q_exp.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard residue actual=%0d expected=0", q_exp.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule